// File: doc/BRIEF.md
# Interlace Coding Mode Selector

This block chooses, for one 16x16 macroblock of signed 16-bit samples, between coding the block as a progressive frame or as two separated fields. It measures vertical activity two ways. The frame measure adds up absolute differences between neighbouring rows. The field measure adds up absolute differences between rows that are two apart, which are rows of the same field. If neighbouring rows differ more than same-parity rows, the content is interlaced and field coding wins.

Rows arrive one per accepted cycle on a 256-bit bus, with column c in bits `[16c+15:16c]`. The block keeps the two most recent rows and adds each new row's contributions to two accumulators. When the sixteenth row is accepted, it compares the totals. A fixed bias is added to the field total first, so ties and near-ties go to frame coding. The block registers a one-bit verdict and pulses `done`. After that it is ready for the next macroblock at once, with no extra `start` needed.

Top module: `fdd_mode_decider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` and `use_field` are 0.
- R2: `done` is high for exactly one cycle, the cycle after the sixteenth row of a macroblock is accepted. At no other time is it high.
- R3: The field total is the sum, over all 16 columns and over row indices r = 0..13, of |row[r+2] - row[r]|. Samples are signed 16-bit two's complement.
- R4: The frame total is the sum, over all 16 columns and over r = 0..14 except r = 7, of |row[r+1] - row[r]|. The pair of rows 7 and 8, where the upper and lower 8x8 blocks meet, is never counted.
- R5: `use_field` is 1 when frame_total >= field_total + BIAS, and 0 otherwise. The comparison is unsigned, BIAS defaults to 350, and an exact tie gives 1.
- R6: While `row_valid` is 0, the bus contents are ignored and the macroblock in progress keeps its state. The verdict equals the one for the same rows sent with no gaps.
- R7: A `start` pulse clears the row count and both totals. If `row_valid` is high in the same cycle, that row becomes row 0 of the new macroblock. A macroblock that is partly received is dropped.
- R8: `use_field` holds its value in every cycle in which `done` is low.
- R9: Differences are formed at 17 bits and the totals do not wrap. Rows that swing between -32768 and 32767 give the correct verdict.
- R10: After `done`, the next sixteen accepted rows form a new macroblock with no `start` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new macroblock; drops any partial one |
| row_valid | input | 1 | A row is on `row_data` this cycle |
| row_data | input | 256 | 16 signed 16-bit samples, column c in bits [16c+15:16c] |
| done | output | 1 | One-cycle pulse carrying a new verdict |
| use_field | output | 1 | 1 = field coding, 0 = frame coding |

## Verification
Every wrong internal state in this block shows up in the same way: the verdict flips, or `done` appears in the wrong cycle. Either is visible one cycle after the last row.

A miscounted row index moves the `done` pulse or shifts which row pairs are counted. A wrong accumulator or bias only shows when the totals sit near the decision line. For that reason, directed macroblocks place the totals exactly on the tie, one bias unit short of it, and just short of the point where counting the block-boundary pair would flip the verdict. Gap cycles carry junk data, and aborted macroblocks are mixed in, so that a leaking row or a stale count corrupts the next verdict.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
  localparam int unsigned FDD_SAMPLE_W = 16;
  localparam int unsigned FDD_COLS     = 16;
  localparam int unsigned FDD_ROWS     = 16;
  localparam int unsigned FDD_BIAS     = 350;
endpackage

// File: rtl/fdd_row_hist.sv
module fdd_row_hist #(
  parameter int unsigned ROW_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_valid,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W-1:0] prev1,
  output logic [ROW_W-1:0] prev2
);
  // Two-deep shift of accepted rows; gaps leave both stages untouched.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev1 <= '0;
      prev2 <= '0;
    end else if (row_valid) begin
      prev2 <= prev1;
      prev1 <= row_in;
    end
  end
endmodule

// File: rtl/fdd_absdiff_sum.sv
module fdd_absdiff_sum #(
  parameter int unsigned SW    = 16,
  parameter int unsigned NCOL  = 16,
  parameter int unsigned SUM_W = SW + $clog2(NCOL)
) (
  input  logic [NCOL*SW-1:0] a,
  input  logic [NCOL*SW-1:0] b,
  output logic [SUM_W-1:0]   sum
);
  localparam int unsigned DW = SW + 1;

  logic [DW-1:0] mag [NCOL];

  // One sign-extended subtractor and magnitude stage per column.
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [SW-1:0] a_c, b_c;
    logic [DW-1:0] diff;
    assign a_c  = a[c*SW +: SW];
    assign b_c  = b[c*SW +: SW];
    assign diff = {a_c[SW-1], a_c} - {b_c[SW-1], b_c};
    // negative difference: invert and add one
    assign mag[c] = diff[DW-1] ? (~diff + 1'b1) : diff;
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < NCOL; c++) begin
      sum = sum + SUM_W'(mag[c]);
    end
  end
endmodule

// File: rtl/fdd_seq.sv
module fdd_seq #(
  parameter int unsigned NROW  = 16,
  parameter int unsigned SUM_W = 20,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned BIAS  = 350
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             row_valid,
  input  logic [SUM_W-1:0] adj_sum,
  input  logic [SUM_W-1:0] skip_sum,
  output logic             done,
  output logic             use_field
);
  localparam int unsigned CNT_W = $clog2(NROW);
  localparam int unsigned LAST  = NROW - 1;
  localparam int unsigned SEAM  = NROW / 2;
  localparam int unsigned CMP_W = ACC_W + 2;

  logic [CNT_W-1:0] cnt, eff_cnt;
  logic [ACC_W-1:0] adj_acc, skip_acc, adj_next, skip_next;
  logic             take_adj, take_skip, last_take;
  logic [CMP_W-1:0] skip_biased;

  assign eff_cnt   = start ? '0 : cnt;
  // seam pair (rows SEAM-1, SEAM) is excluded from the adjacent-row total
  assign take_adj  = (eff_cnt != '0) && (eff_cnt != CNT_W'(SEAM));
  assign take_skip = (eff_cnt >= CNT_W'(2));
  assign last_take = row_valid && (eff_cnt == CNT_W'(LAST));

  always_comb begin
    adj_next  = start ? '0 : adj_acc;
    skip_next = start ? '0 : skip_acc;
    if (row_valid && take_adj)  adj_next  = adj_next  + ACC_W'(adj_sum);
    if (row_valid && take_skip) skip_next = skip_next + ACC_W'(skip_sum);
  end

  assign skip_biased = CMP_W'(skip_next) + CMP_W'(BIAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      adj_acc   <= '0;
      skip_acc  <= '0;
      done      <= 1'b0;
      use_field <= 1'b0;
    end else begin
      done <= last_take;
      if (last_take) begin
        use_field <= (CMP_W'(adj_next) >= skip_biased);
        cnt       <= '0;
        adj_acc   <= '0;
        skip_acc  <= '0;
      end else begin
        adj_acc  <= adj_next;
        skip_acc <= skip_next;
        if (row_valid)  cnt <= eff_cnt + 1'b1;
        else if (start) cnt <= '0;
      end
    end
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_follows_last_r2: assert property (@(posedge clk) disable iff (rst)
    last_take |=> done);
  p_done_cause_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last_take));
  p_verdict_held_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(use_field));
  p_gap_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!row_valid && !start) |=> ($stable(cnt) && $stable(adj_acc) && $stable(skip_acc)));
  p_adj_grows_r4: assert property (@(posedge clk) disable iff (rst)
    (row_valid && !start && !last_take) |=> (adj_acc >= $past(adj_acc)));
  p_skip_grows_r3: assert property (@(posedge clk) disable iff (rst)
    (row_valid && !start && !last_take) |=> (skip_acc >= $past(skip_acc)));
endmodule

// File: rtl/fdd_mode_decider.sv
module fdd_mode_decider #(
  parameter int unsigned SW   = fdd_pkg::FDD_SAMPLE_W,
  parameter int unsigned NCOL = fdd_pkg::FDD_COLS,
  parameter int unsigned NROW = fdd_pkg::FDD_ROWS,
  parameter int unsigned BIAS = fdd_pkg::FDD_BIAS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               row_valid,
  input  logic [NCOL*SW-1:0] row_data,
  output logic               done,
  output logic               use_field
);
  localparam int unsigned ROW_W = NCOL * SW;
  localparam int unsigned SUM_W = SW + $clog2(NCOL);
  localparam int unsigned ACC_W = SW + $clog2(NCOL * (NROW - 2));

  logic [ROW_W-1:0] prev1, prev2;
  logic [SUM_W-1:0] adj_sum, skip_sum;

  fdd_row_hist #(.ROW_W(ROW_W)) u_hist (
    .clk(clk), .rst(rst), .row_valid(row_valid), .row_in(row_data),
    .prev1(prev1), .prev2(prev2)
  );

  fdd_absdiff_sum #(.SW(SW), .NCOL(NCOL), .SUM_W(SUM_W)) u_adj (
    .a(row_data), .b(prev1), .sum(adj_sum)
  );

  fdd_absdiff_sum #(.SW(SW), .NCOL(NCOL), .SUM_W(SUM_W)) u_skip (
    .a(row_data), .b(prev2), .sum(skip_sum)
  );

  fdd_seq #(.NROW(NROW), .SUM_W(SUM_W), .ACC_W(ACC_W), .BIAS(BIAS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
    .adj_sum(adj_sum), .skip_sum(skip_sum),
    .done(done), .use_field(use_field)
  );
endmodule

// File: tb/fdd_mode_decider_bench.sv
module fdd_mode_decider_bench;
  localparam int BIAS = 350;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         row_valid = 1'b0;
  logic [255:0] row_data = '0;
  logic         done, use_field;

  int n_chk = 0;
  int n_bad = 0;
  int mb [16][16];

  always #4 clk = ~clk;

  fdd_mode_decider #(.BIAS(BIAS)) u_fdd_mode_decider (
    .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
    .row_data(row_data), .done(done), .use_field(use_field)
  );

  task automatic check(string req, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint iabs(longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic longint frame_total();
    longint t = 0;
    for (int r = 0; r < 15; r++)
      if (r != 7)
        for (int c = 0; c < 16; c++) t += iabs(longint'(mb[r+1][c]) - mb[r][c]);
    return t;
  endfunction

  function automatic longint field_total();
    longint t = 0;
    for (int r = 0; r < 14; r++)
      for (int c = 0; c < 16; c++) t += iabs(longint'(mb[r+2][c]) - mb[r][c]);
    return t;
  endfunction

  task automatic junk_bus();
    for (int c = 0; c < 16; c++) row_data[c*16 +: 16] = 16'($urandom);
  endtask

  task automatic put_row(int r);
    for (int c = 0; c < 16; c++) row_data[c*16 +: 16] = 16'(mb[r][c]);
  endtask

  task automatic fill_const(int v);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) mb[r][c] = v;
  endtask

  task automatic fill_random(int mode);
    int base = int'($urandom_range(4000)) - 2000;
    int off  = int'($urandom_range(3000));
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        case (mode)
          0:       mb[r][c] = int'($urandom_range(65535)) - 32768;
          1:       mb[r][c] = base + c*7 + r*3 + int'($urandom_range(20));
          default: mb[r][c] = base + ((r % 2) ? off : 0) + int'($urandom_range(20));
        endcase
  endtask

  // Send the macroblock in mb and check verdict and done timing.
  task automatic send_mb(string req, int gap_pct, bit st_first);
    longint f = frame_total();
    longint d = field_total();
    longint e = (f >= d + BIAS) ? 1 : 0;
    for (int r = 0; r < 16; r++) begin
      while (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk);
        check("R2", done, 0, "done during gap");
        start = 1'b0; row_valid = 1'b0; junk_bus();   // R6 junk ignored
      end
      @(negedge clk);
      check("R2", done, 0, "done before last row");
      start = st_first && (r == 0);
      row_valid = 1'b1;
      put_row(r);
    end
    @(negedge clk);
    start = 1'b0; row_valid = 1'b0; junk_bus();
    check("R2", done, 1, "done after last row");
    check(req, use_field, e, "verdict (R3/R4 totals)");
    @(negedge clk);
    check("R2", done, 0, "done one cycle only");
    check("R8", use_field, e, "verdict held");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", done, 0, "done in reset");
    check("R1", use_field, 0, "verdict in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", done, 0, "done after reset");
    check("R1", use_field, 0, "verdict after reset");

    // R5: flat block, totals 0 vs bias -> frame coding
    fill_const(0);
    send_mb("R5", 0, 1);

    // R5: tie 14*25 = 350 -> field coding; 14*24 short -> frame coding
    fill_const(0);
    for (int r = 0; r < 16; r++) mb[r][0] = (r % 2) ? 25 : 0;
    send_mb("R5", 0, 1);
    fill_const(0);
    for (int r = 0; r < 16; r++) mb[r][0] = (r % 2) ? 24 : 0;
    send_mb("R5", 0, 1);

    // R4: seam pair excluded: 14*30=420 vs 2*36+350=422 -> 0
    fill_const(0);
    for (int r = 0; r < 16; r++) begin
      mb[r][1] = (r % 2) ? 30 : 0;
      mb[r][0] = (r >= 8) ? 36 : 0;
    end
    send_mb("R4", 0, 1);

    // R9: full-scale swings, adjacent-row and same-parity variants
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) mb[r][c] = (r % 2) ? 32767 : -32768;
    send_mb("R9", 0, 1);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) mb[r][c] = ((r / 2) % 2) ? 32767 : -32768;
    send_mb("R9", 0, 1);

    // R3/R5: random macroblocks of three kinds, with gaps (R6)
    for (int i = 0; i < 30; i++) begin
      fill_random(i % 3);
      send_mb((i % 2) ? "R6" : "R3", (i % 4 == 0) ? 0 : 40, 1);
    end

    // R7: abandoned partial block, then start carrying row 0
    fill_random(0);
    for (int r = 0; r < 6; r++) begin
      @(negedge clk); start = (r == 0); row_valid = 1'b1; put_row(r);
    end
    fill_random(2);
    send_mb("R7", 0, 1);

    // R7: partial block, then a start pulse with no row
    fill_random(1);
    for (int r = 0; r < 9; r++) begin
      @(negedge clk); start = 1'b0; row_valid = 1'b1; put_row(r);
    end
    @(negedge clk); start = 1'b1; row_valid = 1'b0; junk_bus();
    fill_random(2);
    send_mb("R7", 20, 0);

    // R10: consecutive blocks with no start
    for (int i = 0; i < 4; i++) begin
      fill_random(i % 3);
      send_mb("R10", 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule